// File: doc/BRIEF.md
# Double-Buffered Output Gamma Table

This block is the table store for an output gamma stage. It holds two banks of lookup memory, bank A and bank B. Each bank has one table for each colour channel: red, green and blue. The pixel path looks up one entry per channel in the bank that is currently active, or it bypasses the tables completely. Meanwhile software fills the other bank through a small register port.

The register port is a write-only interface made of a write enable, a 3-bit register address and a data word. The registers are:

| Address | Register | Fields |
|---|---|---|
| 0 | mode | `regWdata[1:0]` |
| 1 | bank select | `regWdata[0]` |
| 2 | host control | `regWdata[2:0]` is the channel write mask, `regWdata[3]` is the host bank |
| 3 | index | `regWdata[ADDR_W-1:0]` |
| 4 | data | `regWdata[DATA_W-1:0]` |

The mode and bank select values are held as pending values. They move into the current values only on a frame-start pulse, so the pixel path never changes tables part way through a frame. The update sequence is:

1. Point the host bank at the bank that is not in use.
2. Write index 0.
3. Stream N+1 data words for each channel, or one stream with mask 7 when all channels share the curve.
4. Write the new select value.
5. Let the next frame start apply it.

Top module: `gamma_bank_lut`

## Requirements
- R1: After reset, `curMode` is 0, `curSel` is 0, and the pixel path is in bypass.
- R2: When `curMode` is 0, each pixel output equals the matching input, zero-extended to `DATA_W`. It appears one clock after the input is sampled.
- R3: When `curMode` is 2, each output is the table entry at the input value, read from the bank named by `curSel` (0 = A, 1 = B). It appears one clock after the input is sampled.
- R4: Mode values 1 and 3 are reported unchanged on `curMode`, but the pixel path behaves as bypass.
- R5: Writes to mode (address 0) and select (address 1) do not change `curMode`, `curSel` or the pixel path until a `frameStart` pulse. The new values are in effect from the clock after that pulse.
- R6: Host bank bit `regWdata[3]` of address 2 picks the bank that data writes go to: 0 writes bank A and 1 writes bank B. It does not depend on which bank is active.
- R7: Mask `regWdata[2:0]` of address 2 gates the channels: bit 2 is red, bit 1 is green and bit 0 is blue. Mask 7 writes one word into all three channels. Mask 0 writes nothing.
- R8: A write to address 3 sets the entry index. Each write to address 4 stores the word at that index and then adds 1 to the index. The index wraps from `2**ADDR_W-1` to 0.
- R9: Loading the inactive bank leaves the output of the active bank unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| regWe | input | 1 | Register write strobe |
| regAddr | input | 3 | Register address (0 mode, 1 select, 2 host control, 3 index, 4 data) |
| regWdata | input | DATA_W | Register write data |
| frameStart | input | 1 | Frame boundary pulse that applies the pending mode and select |
| pixR | input | ADDR_W | Red pixel input |
| pixG | input | ADDR_W | Green pixel input |
| pixB | input | ADDR_W | Blue pixel input |
| outR | output | DATA_W | Red result |
| outG | output | DATA_W | Green result |
| outB | output | DATA_W | Blue result |
| curMode | output | 2 | Mode now in effect |
| curSel | output | 1 | Bank now in use |

## Verification
The bench checks the status and the pixel output between the mode and select writes and the frame-start pulse. A design that latched those writes at once would switch tables mid-frame and fail there. It loads each channel alone with single-bit masks and then sends one mask-0 write, which catches a swapped mask-bit order and a write that ignores the mask. It writes across the top index, which exposes an index that saturates instead of wrapping. It also programs the reserved modes 1 and 3, which a design decoding only bit 1 of the mode would wrongly treat as table mode.

// File: rtl/gamma_lut_pkg.sv
package gamma_lut_pkg;

  typedef enum logic [2:0] {
    REG_MODE  = 3'd0,
    REG_SEL   = 3'd1,
    REG_HOST  = 3'd2,
    REG_INDEX = 3'd3,
    REG_DATA  = 3'd4
  } regAddr_e;

  localparam logic [1:0] MODE_BYPASS = 2'd0;
  localparam logic [1:0] MODE_TABLE  = 2'd2;

  // Control-to-datapath strobes; mask bit 2 = red, 1 = green, 0 = blue
  typedef struct packed {
    logic       lutWr;
    logic       bank;
    logic [2:0] mask;
  } lutStrobe_t;

endpackage

// File: rtl/gamma_ctrl.sv
module gamma_ctrl
  import gamma_lut_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              regWe,
  input  logic [2:0]        regAddr,
  input  logic [DATA_W-1:0] regWdata,
  input  logic              frameStart,
  output lutStrobe_t        strb,
  output logic [ADDR_W-1:0] wrIdx,
  output logic [1:0]        curMode,
  output logic              curSel,
  output logic              useLut
);

  logic [1:0] pendMode;
  logic       pendSel;
  logic [2:0] hostMask;
  logic       hostBank;

  wire wrMode  = regWe && (regAddr == REG_MODE);
  wire wrSel   = regWe && (regAddr == REG_SEL);
  wire wrHost  = regWe && (regAddr == REG_HOST);
  wire wrIndex = regWe && (regAddr == REG_INDEX);
  wire wrData  = regWe && (regAddr == REG_DATA);

  always_ff @(posedge clk) begin
    if (rst) begin
      pendMode <= MODE_BYPASS;
      pendSel  <= 1'b0;
      curMode  <= MODE_BYPASS;
      curSel   <= 1'b0;
      hostMask <= 3'd0;
      hostBank <= 1'b0;
      wrIdx    <= '0;
    end else begin
      if (wrMode) pendMode <= regWdata[1:0];
      if (wrSel)  pendSel  <= regWdata[0];
      if (wrHost) begin
        hostMask <= regWdata[2:0];
        hostBank <= regWdata[3];
      end
      if (wrIndex)     wrIdx <= regWdata[ADDR_W-1:0];
      else if (wrData) wrIdx <= wrIdx + 1'b1;
      if (frameStart) begin
        curMode <= pendMode;
        curSel  <= pendSel;
      end
    end
  end

  always_comb begin
    strb.lutWr = wrData;
    strb.bank  = hostBank;
    strb.mask  = hostMask;
  end

  // Reserved mode codes fall back to bypass
  assign useLut = (curMode == MODE_TABLE);

  // R5
  cur_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !frameStart |=> $stable(curMode) && $stable(curSel));

  // R8
  idx_step_chk: assert property (@(posedge clk) disable iff (rst)
    (regWe && regAddr == REG_DATA) |=> wrIdx == ADDR_W'($past(wrIdx) + 1'b1));

  // R8
  idx_load_chk: assert property (@(posedge clk) disable iff (rst)
    (regWe && regAddr == REG_INDEX) |=> wrIdx == $past(regWdata[ADDR_W-1:0]));

endmodule

// File: rtl/gamma_datapath.sv
module gamma_datapath
  import gamma_lut_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  lutStrobe_t        strb,
  input  logic [ADDR_W-1:0] wrIdx,
  input  logic [DATA_W-1:0] wrData,
  input  logic              useLut,
  input  logic              rdBank,
  input  logic [ADDR_W-1:0] pixIn  [3],
  output logic [DATA_W-1:0] pixOut [3]
);

  localparam int DEPTH = 1 << ADDR_W;

  for (genvar ch = 0; ch < 3; ch++) begin : chanG
    logic [DATA_W-1:0] ramA [DEPTH];
    logic [DATA_W-1:0] ramB [DEPTH];
    // channel 0 red -> mask bit 2, 1 green -> bit 1, 2 blue -> bit 0
    wire chWr = strb.lutWr && strb.mask[2-ch];

    always_ff @(posedge clk) begin
      if (chWr && !strb.bank) ramA[wrIdx] <= wrData;
      if (chWr &&  strb.bank) ramB[wrIdx] <= wrData;
    end

    always_ff @(posedge clk) begin
      if (rst)         pixOut[ch] <= '0;
      else if (!useLut) pixOut[ch] <= DATA_W'(pixIn[ch]);
      else if (rdBank)  pixOut[ch] <= ramB[pixIn[ch]];
      else              pixOut[ch] <= ramA[pixIn[ch]];
    end

    // R2
    bypass_pass_chk: assert property (@(posedge clk) disable iff (rst)
      !useLut |=> pixOut[ch] == DATA_W'($past(pixIn[ch])));
  end

endmodule

// File: rtl/gamma_bank_lut.sv
module gamma_bank_lut
  import gamma_lut_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              regWe,
  input  logic [2:0]        regAddr,
  input  logic [DATA_W-1:0] regWdata,
  input  logic              frameStart,
  input  logic [ADDR_W-1:0] pixR,
  input  logic [ADDR_W-1:0] pixG,
  input  logic [ADDR_W-1:0] pixB,
  output logic [DATA_W-1:0] outR,
  output logic [DATA_W-1:0] outG,
  output logic [DATA_W-1:0] outB,
  output logic [1:0]        curMode,
  output logic              curSel
);

  lutStrobe_t        strb;
  logic [ADDR_W-1:0] wrIdx;
  logic              useLut;
  logic [ADDR_W-1:0] pixIn  [3];
  logic [DATA_W-1:0] pixOut [3];

  assign pixIn[0] = pixR;
  assign pixIn[1] = pixG;
  assign pixIn[2] = pixB;
  assign outR = pixOut[0];
  assign outG = pixOut[1];
  assign outB = pixOut[2];

  gamma_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) ctrlU (
    .clk(clk), .rst(rst), .regWe(regWe), .regAddr(regAddr),
    .regWdata(regWdata), .frameStart(frameStart), .strb(strb),
    .wrIdx(wrIdx), .curMode(curMode), .curSel(curSel), .useLut(useLut)
  );

  gamma_datapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) dpU (
    .clk(clk), .rst(rst), .strb(strb), .wrIdx(wrIdx), .wrData(regWdata),
    .useLut(useLut), .rdBank(curSel), .pixIn(pixIn), .pixOut(pixOut)
  );

endmodule

// File: tb/tb_gamma_bank_lut.sv
`timescale 1ns/1ps
module tb_gamma_bank_lut;
  localparam int AW = 6;
  localparam int DW = 10;

  logic clk = 0;
  logic rst = 1;
  logic regWe = 0;
  logic [2:0] regAddr = 0;
  logic [DW-1:0] regWdata = 0;
  logic frameStart = 0;
  logic [AW-1:0] pixR = 0, pixG = 0, pixB = 0;
  logic [DW-1:0] outR, outG, outB;
  logic [1:0] curMode;
  logic curSel;
  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  gamma_bank_lut #(.ADDR_W(AW), .DATA_W(DW)) dut (
    .clk(clk), .rst(rst), .regWe(regWe), .regAddr(regAddr),
    .regWdata(regWdata), .frameStart(frameStart), .pixR(pixR), .pixG(pixG),
    .pixB(pixB), .outR(outR), .outG(outG), .outB(outB),
    .curMode(curMode), .curSel(curSel)
  );

  task automatic regWrite(input logic [2:0] a, input int d);
    @(negedge clk);
    regWe = 1; regAddr = a; regWdata = DW'(d);
    @(negedge clk);
    regWe = 0;
  endtask

  task automatic pulseFrame();
    @(negedge clk);
    frameStart = 1;
    @(negedge clk);
    frameStart = 0;
  endtask

  task automatic checkStatus(input int m, input int s, input string tag);
    checks++;
    if (curMode !== 2'(m) || curSel !== 1'(s)) begin
      errors++;
      $display("FAIL %s status mode=%0d sel=%0d expected mode=%0d sel=%0d",
               tag, curMode, curSel, m, s);
    end
  endtask

  task automatic checkPix(input int r, input int g, input int b,
                          input int er, input int eg, input int eb, input string tag);
    @(negedge clk);
    pixR = AW'(r); pixG = AW'(g); pixB = AW'(b);
    @(negedge clk);
    checks++;
    if (outR !== DW'(er) || outG !== DW'(eg) || outB !== DW'(eb)) begin
      errors++;
      $display("FAIL %s pixel out=%0d,%0d,%0d expected %0d,%0d,%0d",
               tag, outR, outG, outB, er, eg, eb);
    end
  endtask

  task automatic testReset();
    checkStatus(0, 0, "R1");
    checkPix(5, 6, 7, 5, 6, 7, "R1");
  endtask

  // bank A: all entries 3i+1, then first 8 of each channel overwritten per channel
  task automatic testLoadA();
    regWrite(REG_HOST_A(), 7);
    regWrite(3, 0);
    for (int i = 0; i < 64; i++) regWrite(4, 3*i+1);
    regWrite(2, 4); regWrite(3, 0);
    for (int i = 0; i < 8; i++) regWrite(4, 500+i);
    regWrite(2, 2); regWrite(3, 0);
    for (int i = 0; i < 8; i++) regWrite(4, 600+i);
    regWrite(2, 1); regWrite(3, 0);
    for (int i = 0; i < 8; i++) regWrite(4, 700+i);
    regWrite(0, 2); regWrite(1, 0);
    checkStatus(0, 0, "R5");
    checkPix(3, 3, 3, 3, 3, 3, "R5");
    pulseFrame();
    checkStatus(2, 0, "R5");
    checkPix(3, 3, 3, 503, 603, 703, "R7");
    checkPix(20, 21, 22, 61, 64, 67, "R3");
  endtask

  function automatic logic [2:0] REG_HOST_A();
    return 3'd2;
  endfunction

  task automatic testLoadB();
    regWrite(2, 8 | 7);
    regWrite(3, 0);
    for (int i = 0; i < 64; i++) regWrite(4, 900-i);
    checkPix(3, 3, 3, 503, 603, 703, "R9");
    checkPix(40, 40, 40, 121, 121, 121, "R6");
    regWrite(1, 1);
    checkStatus(2, 0, "R5");
    pulseFrame();
    checkStatus(2, 1, "R5");
    checkPix(2, 5, 63, 898, 895, 837, "R3");
    regWrite(2, 8); regWrite(3, 10); regWrite(4, 1);
    checkPix(10, 10, 10, 890, 890, 890, "R7");
    // host bank A while B active: bank B unaffected
    regWrite(2, 7); regWrite(3, 11); regWrite(4, 5);
    checkPix(11, 11, 11, 889, 889, 889, "R6");
    regWrite(2, 8 | 7); regWrite(3, 63); regWrite(4, 11); regWrite(4, 22);
    checkPix(63, 0, 63, 11, 22, 11, "R8");
    regWrite(1, 0);
    pulseFrame();
    checkPix(11, 11, 11, 5, 5, 5, "R6");
  endtask

  task automatic testReserved();
    regWrite(0, 1);
    pulseFrame();
    checkStatus(1, 0, "R4");
    checkPix(11, 12, 13, 11, 12, 13, "R4");
    regWrite(0, 3);
    pulseFrame();
    checkStatus(3, 0, "R4");
    checkPix(63, 0, 9, 63, 0, 9, "R4");
    regWrite(0, 0);
    pulseFrame();
    checkStatus(0, 0, "R2");
    checkPix(40, 41, 42, 40, 41, 42, "R2");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    testReset();
    testLoadA();
    testLoadB();
    testReserved();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule